// File: doc/BRIEF.md
# Addressed Interrupt Message Router

This block collects 24 device interrupt lines and turns each event into an addressed message. Every input owns a 64-bit configuration entry that software fills in at setup time. A rising edge on an enabled input makes the block build a message from that input's entry, holding a destination ID and an 8-bit vector. The message goes onto one shared internal bus. Several per-core receiver units watch that bus. Only the receiver whose ID equals the destination takes the message. It then raises a request toward its core and keeps the vector there until the core acknowledges.

Software reaches the entries through two 32-bit locations. One is an index register that selects an entry half. The other is a data window onto the selected half. The message bus is brought out as read-only outputs so that a system can observe it.

Top module: `irq_msg_router`

## Requirements
- R1: After reset, each entry reads 0x00010000 in its low half and 0 in its high half, so every entry is masked. No core request is raised and the bus shows no valid message.
- R2: A write with regSel=0 loads the index from regWrData[5:0]. The entry is index[5:1], and index[0]=1 selects the high half. A write with regSel=1 stores regWrData into the selected half. A read of either location returns the value last written there. The data window reads 0 for an index beyond the last entry.
- R3: Entry fields: vector in bits [7:0], mask in bit 16, destination ID in bits [63:56]. A rising edge on an unmasked input puts a message on the bus on the second clock edge. The matching core request rises on the third edge, carrying that entry's vector.
- R4: An input whose mask bit is 1 produces no message.
- R5: Inputs listed as reserved (by default 22 and 23) never produce a message, whatever their entry holds.
- R6: Receiver k has ID k. Only the receiver whose ID equals the destination accepts a message; the other receivers do not change. A message whose destination matches no receiver is taken off the bus and dropped.
- R7: When several inputs are pending, the lowest-numbered one is sent first. At most one message goes onto the bus per cycle.
- R8: A receiver that holds a request refuses messages addressed to it. Such a message stays valid and unchanged on the bus, and is delivered after the core acknowledges.
- R9: A core request and its vector stay unchanged until coreAck for that core is high at a clock edge.
- R10: Inputs are edge-triggered. An input held high yields exactly one message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | 24 | Device interrupt lines |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 selects the index register, 1 selects the data window |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data of the location chosen by regSel |
| msgValid | output | 1 | Message valid on the shared bus |
| msgDest | output | 8 | Destination ID of the bus message |
| msgVec | output | 8 | Vector of the bus message |
| coreReq | output | 4 | Pending request per core |
| coreVec | output | 32 | Vector per core, 8 bits each, core 0 in the low byte |
| coreAck | input | 4 | Per-core acknowledge |

## Verification
The bench targets two inputs that fire together toward a receiver that is already busy. A design with the wrong priority would deliver input 5 before input 2. A design that lets the bus message slip would lose the second vector or swap it while it waits. A destination that matches no receiver checks that the bus drains: if it does not, msgValid stays high and stalls all later traffic. Masked inputs, reserved inputs and an input held high check for messages that should never appear: a design that triggers on level or ignores the mask bit would raise a request there.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int ENTRY_W  = 64;
  localparam int VEC_LSB  = 0;
  localparam int MASK_BIT = 16;
  localparam int DEST_LSB = 56;
  localparam int SEL_W    = 8;

  typedef struct packed {
    logic             loadMsg;
    logic [SEL_W-1:0] selIdx;
  } strb_t;
endpackage

// File: rtl/irq_router_ctrl.sv
module irq_router_ctrl
  import irq_router_pkg::*;
#(
  parameter int NUM_IN = 24,
  parameter logic [NUM_IN-1:0] RSVD_MAP = 24'hC00000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] irqIn,
  input  logic [NUM_IN-1:0] entryMask,
  input  logic              busReady,
  output strb_t             strb,
  output logic              busValid
);
  logic [NUM_IN-1:0] prevIn, pending, arm, clr;

  assign arm = irqIn & ~prevIn & ~entryMask & ~RSVD_MAP;

  always_comb begin
    strb.selIdx = '0;
    for (int i = NUM_IN - 1; i >= 0; i--)
      if (pending[i]) strb.selIdx = SEL_W'(i);
    strb.loadMsg = (|pending) && (!busValid || busReady);
    for (int i = 0; i < NUM_IN; i++)
      clr[i] = strb.loadMsg && (strb.selIdx == SEL_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevIn   <= '0;
      pending  <= '0;
      busValid <= 1'b0;
    end else begin
      prevIn  <= irqIn;
      pending <= (pending & ~clr) | arm;
      if (strb.loadMsg)  busValid <= 1'b1;
      else if (busReady) busValid <= 1'b0;
    end
  end

  // R8
  held_msg_chk: assert property (@(posedge clk) disable iff (!rstN)
    busValid && !busReady |=> busValid);

  // R5
  no_reserved_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pending & RSVD_MAP) == '0);
endmodule

// File: rtl/irq_router_dp.sv
module irq_router_dp
  import irq_router_pkg::*;
#(
  parameter int NUM_IN = 24,
  parameter int ID_W   = 8,
  parameter int VEC_W  = 8,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  strb_t             strb,
  output logic [NUM_IN-1:0] entryMask,
  output logic [ID_W-1:0]   msgDest,
  output logic [VEC_W-1:0]  msgVec
);
  localparam int IDX_W = $clog2(2 * NUM_IN);
  localparam logic [ENTRY_W-1:0] RST_ENTRY = ENTRY_W'(1) << MASK_BIT;

  logic [ENTRY_W-1:0] tbl [NUM_IN];
  logic [IDX_W-1:0]   regIdx;
  logic [ENTRY_W-1:0] winEntry, selEntry;
  logic               winHit;

  always_comb begin
    winEntry = '0;
    winHit   = 1'b0;
    selEntry = '0;
    for (int e = 0; e < NUM_IN; e++) begin
      if (regIdx[IDX_W-1:1] == (IDX_W-1)'(e)) begin
        winEntry = tbl[e];
        winHit   = 1'b1;
      end
      if (strb.selIdx == SEL_W'(e)) selEntry = tbl[e];
      entryMask[e] = tbl[e][MASK_BIT];
    end
  end

  always_comb begin
    if (!regSel)        regRdData = REG_W'(regIdx);
    else if (!winHit)   regRdData = '0;
    else if (regIdx[0]) regRdData = winEntry[ENTRY_W-1:REG_W];
    else                regRdData = winEntry[REG_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regIdx  <= '0;
      msgDest <= '0;
      msgVec  <= '0;
      for (int e = 0; e < NUM_IN; e++) tbl[e] <= RST_ENTRY;
    end else begin
      if (regWrEn && !regSel) regIdx <= regWrData[IDX_W-1:0];
      if (regWrEn && regSel)
        for (int e = 0; e < NUM_IN; e++)
          if (regIdx[IDX_W-1:1] == (IDX_W-1)'(e)) begin
            if (regIdx[0]) tbl[e][ENTRY_W-1:REG_W] <= regWrData;
            else           tbl[e][REG_W-1:0]       <= regWrData;
          end
      if (strb.loadMsg) begin
        msgDest <= selEntry[DEST_LSB +: ID_W];
        msgVec  <= selEntry[VEC_LSB +: VEC_W];
      end
    end
  end
endmodule

// File: rtl/irq_router_rx.sv
module irq_router_rx #(
  parameter int ID_W  = 8,
  parameter int VEC_W = 8,
  parameter logic [ID_W-1:0] MY_ID = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busValid,
  input  logic [ID_W-1:0]  busDest,
  input  logic [VEC_W-1:0] busVec,
  output logic             rxReady,
  output logic             coreReq,
  output logic [VEC_W-1:0] coreVec,
  input  logic             coreAck
);
  logic match;
  assign match   = busDest == MY_ID;
  assign rxReady = !(match && coreReq);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      coreReq <= 1'b0;
      coreVec <= '0;
    end else if (coreReq) begin
      if (coreAck) coreReq <= 1'b0;
    end else if (busValid && match) begin
      coreReq <= 1'b1;
      coreVec <= busVec;
    end
  end

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    coreReq && !coreAck |=> coreReq && $stable(coreVec));

  // R6
  id_filter_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(coreReq) |-> $past(busValid && busDest == MY_ID));
endmodule

// File: rtl/irq_msg_router.sv
module irq_msg_router
  import irq_router_pkg::*;
#(
  parameter int NUM_IN = 24,
  parameter int NUM_RX = 4,
  parameter int ID_W   = 8,
  parameter int VEC_W  = 8,
  parameter int REG_W  = 32,
  parameter logic [NUM_IN-1:0] RSVD_MAP = 24'hC00000
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_IN-1:0]       irqIn,
  input  logic                    regWrEn,
  input  logic                    regSel,
  input  logic [REG_W-1:0]        regWrData,
  output logic [REG_W-1:0]        regRdData,
  output logic                    msgValid,
  output logic [ID_W-1:0]         msgDest,
  output logic [VEC_W-1:0]        msgVec,
  output logic [NUM_RX-1:0]       coreReq,
  output logic [NUM_RX*VEC_W-1:0] coreVec,
  input  logic [NUM_RX-1:0]       coreAck
);
  strb_t             strb;
  logic [NUM_IN-1:0] entryMask;
  logic [NUM_RX-1:0] rxReady;
  logic              busReady;

  assign busReady = &rxReady;

  irq_router_ctrl #(.NUM_IN(NUM_IN), .RSVD_MAP(RSVD_MAP)) u_ctrl (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .entryMask(entryMask),
    .busReady(busReady), .strb(strb), .busValid(msgValid));

  irq_router_dp #(.NUM_IN(NUM_IN), .ID_W(ID_W), .VEC_W(VEC_W), .REG_W(REG_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData), .strb(strb),
    .entryMask(entryMask), .msgDest(msgDest), .msgVec(msgVec));

  for (genvar k = 0; k < NUM_RX; k++) begin : g_rx
    irq_router_rx #(.ID_W(ID_W), .VEC_W(VEC_W), .MY_ID(ID_W'(k))) u_rx (
      .clk(clk), .rstN(rstN), .busValid(msgValid), .busDest(msgDest),
      .busVec(msgVec), .rxReady(rxReady[k]), .coreReq(coreReq[k]),
      .coreVec(coreVec[k*VEC_W +: VEC_W]), .coreAck(coreAck[k]));
  end

  // R8
  bus_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && !busReady |=> msgValid && $stable(msgDest) && $stable(msgVec));
endmodule

// File: tb/irq_msg_router_bench.sv
module irq_msg_router_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] irqIn = '0;
  logic        regWrEn = 1'b0, regSel = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        msgValid;
  logic [7:0]  msgDest, msgVec;
  logic [3:0]  coreReq, coreAck = '0;
  logic [31:0] coreVec;
  int nChk = 0, nFail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_msg_router u_irq_msg_router (.*);

  // {input, dest, vector, unused}
  localparam logic [31:0] VECS [6] = '{
    32'h00_00_20_00, 32'h07_01_41_00, 32'h0D_02_7F_00,
    32'h15_03_FF_00, 32'h01_03_00_00, 32'h14_00_90_00};

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic sel, logic [31:0] d);
    regSel = sel; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic prog(int idx, logic [7:0] dest, logic [7:0] vec, logic msk);
    wr(0, 32'(idx * 2));
    wr(1, {15'h0, msk, 8'h0, vec});
    wr(0, 32'(idx * 2 + 1));
    wr(1, {dest, 24'h0});
  endtask

  // raise, drop after one cycle, return just after the third edge
  task automatic fire(logic [23:0] bits);
    irqIn = bits;
    @(negedge clk);
    irqIn = '0;
    repeat (2) @(negedge clk);
  endtask

  task automatic ack(int k);
    coreAck[k] = 1'b1;
    @(negedge clk);
    coreAck = '0;
    @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 req", 32'(coreReq), 0);
    check("R1 valid", 32'(msgValid), 0);
    wr(0, 32'd10); regSel = 1'b1; #1;
    check("R1 low", regRdData, 32'h00010000);
    wr(0, 32'd11); regSel = 1'b1; #1;
    check("R1 high", regRdData, 0);
    // R2 readback
    wr(0, 32'd19); regSel = 1'b0; #1;
    check("R2 index", regRdData, 32'd19);
    wr(1, 32'hCAFE1234); #1;
    check("R2 data", regRdData, 32'hCAFE1234);
    wr(0, 32'd50); regSel = 1'b1; #1;
    check("R2 beyond", regRdData, 0);

    // R3 / R6 / R9 vector walk
    for (int v = 0; v < 6; v++) begin
      int idx = int'(VECS[v][31:24]);
      int dst = int'(VECS[v][23:16]);
      logic [7:0] vc = VECS[v][15:8];
      prog(idx, 8'(dst), vc, 1'b0);
      fire(24'(1) << idx);
      check("R3 req", 32'(coreReq), 32'(4'(1) << dst));
      check("R3 vec", 32'(coreVec[dst*8 +: 8]), 32'(vc));
      repeat (3) @(negedge clk);
      check("R9 held", 32'(coreReq), 32'(4'(1) << dst));
      check("R9 vec", 32'(coreVec[dst*8 +: 8]), 32'(vc));
      ack(dst);
      check("R9 ack", 32'(coreReq), 0);
    end

    // R4 masked entry
    prog(4, 8'd0, 8'h44, 1'b1);
    fire(24'h10);
    repeat (2) @(negedge clk);
    check("R4 req", 32'(coreReq), 0);
    check("R4 valid", 32'(msgValid), 0);
    // R5 reserved input
    prog(22, 8'd0, 8'h05, 1'b0);
    fire(24'h400000);
    repeat (2) @(negedge clk);
    check("R5 req", 32'(coreReq), 0);
    check("R5 valid", 32'(msgValid), 0);
    // R6 unmatched destination is dropped
    prog(3, 8'd9, 8'h33, 1'b0);
    fire(24'h8);
    check("R6 none", 32'(coreReq), 0);
    check("R6 drained", 32'(msgValid), 0);
    // R10 level held high
    prog(6, 8'd2, 8'h66, 1'b0);
    irqIn = 24'h40;
    repeat (3) @(negedge clk);
    check("R10 first", 32'(coreReq), 32'h4);
    ack(2);
    repeat (4) @(negedge clk);
    check("R10 once", 32'(coreReq), 0);
    irqIn = '0;
    // R7 / R8 priority and back-pressure
    prog(2, 8'd1, 8'h22, 1'b0);
    prog(5, 8'd1, 8'h55, 1'b0);
    fire(24'h24);
    check("R7 first", 32'(coreVec[15:8]), 32'h22);
    check("R8 valid", 32'(msgValid), 1);
    check("R8 vec", 32'(msgVec), 32'h55);
    repeat (3) @(negedge clk);
    check("R8 still", {msgValid, msgDest, msgVec}, {15'h0, 1'b1, 8'd1, 8'h55});
    ack(1);
    check("R8 delivered", 32'(coreReq), 32'h2);
    check("R7 second", 32'(coreVec[15:8]), 32'h55);
    ack(1);
    check("R7 empty", 32'(msgValid), 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        nChk++; nFail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule